// File: doc/BRIEF.md
# EDID Base Block Validator

This block watches a 128-byte display identification block as it streams past, one byte per accepted cycle, each byte tagged with its offset. In a single pass it compares the first eight bytes against the fixed header pattern, keeps a running 8-bit wrapping sum of every byte, and captures the three bytes at offsets 35, 36 and 37, which hold the established-timing bitmaps. Fetching the bytes and decoding any other field are left to neighbouring logic.

A transfer is opened by `start_i`. A byte offered in the same cycle as `start_i` counts as part of the new block. When the byte with offset 127 is accepted, `done_o` rises one cycle later, together with the header flag, the checksum flag, the overall valid flag and the captured bitmaps. These results stay frozen until the next `start_i` or `abort_i`. `abort_i` wipes all state so that an interrupted transfer never reports a valid block. Bytes are expected in ascending offset order.

Top module: `edid_block_check`

## Requirements
- R1: `hdr_ok_o` is 1 after completion when bytes at offsets 0 and 7 are 0x00 and bytes at offsets 1 to 6 are 0xFF.
- R2: Any mismatch in offsets 0 to 7 drives `hdr_ok_o` and `valid_o` to 0, whatever the checksum is.
- R3: `sum_ok_o` is 1 after completion exactly when the modulo-256 sum of all 128 bytes is 0x00.
- R4: `valid_o` is 1 only when both `hdr_ok_o` and `sum_ok_o` are 1.
- R5: `est_o[7:0]` holds the byte at offset 35, `est_o[15:8]` the byte at offset 36, and `est_o[23:16]` the byte at offset 37.
- R6: `done_o` rises in the cycle after the byte with offset 127 is accepted. While `done_o` is 0, the three flags and `est_o` are all 0.
- R7: Once `done_o` is 1, all results hold steady until `start_i` or `abort_i`. Bytes offered in that interval have no effect.
- R8: `abort_i` clears all state in the next cycle and takes priority over a byte or a `start_i` in the same cycle. Bytes offered after an abort are ignored until `start_i`.
- R9: `start_i` clears any earlier results (`done_o` is 0 in the next cycle). A byte offered in the same cycle as `start_i` is accepted as part of the new block.
- R10: After reset, `done_o`, all flags and `est_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new block and clears earlier results |
| abort_i | input | 1 | Discards the transfer in progress and all results |
| byte_vld_i | input | 1 | A byte is offered this cycle |
| byte_idx_i | input | 7 | Offset of the offered byte within the block |
| byte_i | input | 8 | Offered byte |
| done_o | output | 1 | Results are present and stable |
| hdr_ok_o | output | 1 | Header pattern matched |
| sum_ok_o | output | 1 | Wrapping byte sum is zero |
| valid_o | output | 1 | Header and checksum both passed |
| est_o | output | 24 | Established-timing bytes at offsets 35, 36 and 37 |

## Verification
Two pairs of actions can fall in the same cycle. The first is an abort arriving together with the final byte at offset 127. The second is a start arriving together with the first byte of a block. The bench drives both on purpose. In the first case it expects `done_o` to stay low and a later repeat of byte 127 to be ignored. In the second case it expects the opening byte to be counted, so that a well-formed block still comes out valid. Randomly generated blocks with a corrupted header, a corrupted checksum or both, each opened either with a separate start or with a start on byte 0, are compared against header, sum and bitmap values that the bench works out itself.

// File: rtl/edid_chk_pkg.sv
package edid_chk_pkg;
  localparam int unsigned BLK_BYTES = 128;
  localparam int unsigned HDR_LEN   = 8;
  localparam int unsigned EST_BASE  = 35;
  localparam int unsigned EST_NUM   = 3;
  localparam int unsigned DATA_W    = 8;
endpackage

// File: rtl/edid_hdr_check.sv
module edid_hdr_check #(
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned HDR_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              acc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              bad_o
);
  logic              bad_q;
  logic              in_hdr;
  logic [DATA_W-1:0] pattern;
  logic              miss;

  // header framing bytes are zero, the interior bytes are all ones
  assign in_hdr  = idx_i < IDX_W'(HDR_LEN);
  assign pattern = (idx_i == '0 || idx_i == IDX_W'(HDR_LEN - 1)) ? '0 : '1;
  assign miss    = acc_i && in_hdr && (byte_i != pattern);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              bad_q <= 1'b0;
    else if (clr_i || acc_i)  bad_q <= (bad_q && !clr_i) || miss;
  end

  assign bad_o = bad_q;
endmodule

// File: rtl/edid_sum_acc.sv
module edid_sum_acc #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              acc_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              zero_o
);
  logic [DATA_W-1:0] sum_q;
  logic [DATA_W-1:0] base;

  assign base = clr_i ? '0 : sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= '0;
    else if (acc_i)   sum_q <= base + byte_i;
    else if (clr_i)   sum_q <= '0;
  end

  assign zero_o = (sum_q == '0);
endmodule

// File: rtl/edid_field_latch.sv
module edid_field_latch #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE   = 35,
  parameter int unsigned NUM    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  acc_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [DATA_W-1:0]     byte_i,
  output logic [NUM*DATA_W-1:0] fields_o
);
  for (genvar k = 0; k < NUM; k++) begin : g_fld
    logic [DATA_W-1:0] fld_q;
    logic              hit;
    assign hit = acc_i && (idx_i == IDX_W'(BASE + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     fld_q <= '0;
      else if (hit)    fld_q <= byte_i;
      else if (clr_i)  fld_q <= '0;
    end
    assign fields_o[k*DATA_W +: DATA_W] = fld_q;
  end
endmodule

// File: rtl/edid_block_check.sv
module edid_block_check #(
  parameter int unsigned BLK_BYTES = edid_chk_pkg::BLK_BYTES,
  parameter int unsigned HDR_LEN   = edid_chk_pkg::HDR_LEN,
  parameter int unsigned EST_BASE  = edid_chk_pkg::EST_BASE,
  parameter int unsigned EST_NUM   = edid_chk_pkg::EST_NUM,
  parameter int unsigned DATA_W    = edid_chk_pkg::DATA_W,
  localparam int unsigned IDX_W    = $clog2(BLK_BYTES),
  localparam int unsigned EST_W    = EST_NUM * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              byte_vld_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              done_o,
  output logic              hdr_ok_o,
  output logic              sum_ok_o,
  output logic              valid_o,
  output logic [EST_W-1:0]  est_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  logic             active_q, done_q;
  logic             clr, acc, last;
  logic             hdr_bad, sum_zero;
  logic [EST_W-1:0] est_raw;

  // abort outranks start and data
  assign clr  = abort_i || start_i;
  assign acc  = byte_vld_i && !abort_i && (active_q || start_i);
  assign last = acc && (byte_idx_i == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (last)          active_q <= 1'b0;
      else if (start_i)  active_q <= 1'b1;
      if (last)          done_q   <= 1'b1;
      else if (start_i)  done_q   <= 1'b0;
    end
  end

  edid_hdr_check #(.IDX_W(IDX_W), .DATA_W(DATA_W), .HDR_LEN(HDR_LEN)) u_hdr (
    .clk_i, .rst_ni, .clr_i(clr), .acc_i(acc),
    .idx_i(byte_idx_i), .byte_i, .bad_o(hdr_bad)
  );

  edid_sum_acc #(.DATA_W(DATA_W)) u_sum (
    .clk_i, .rst_ni, .clr_i(clr), .acc_i(acc), .byte_i, .zero_o(sum_zero)
  );

  edid_field_latch #(.IDX_W(IDX_W), .DATA_W(DATA_W), .BASE(EST_BASE), .NUM(EST_NUM)) u_est (
    .clk_i, .rst_ni, .clr_i(clr), .acc_i(acc),
    .idx_i(byte_idx_i), .byte_i, .fields_o(est_raw)
  );

  assign done_o   = done_q;
  assign hdr_ok_o = done_q && !hdr_bad;
  assign sum_ok_o = done_q && sum_zero;
  assign valid_o  = hdr_ok_o && sum_ok_o;
  assign est_o    = done_q ? est_raw : '0;
endmodule

// File: rtl/edid_block_check_chk.sv
module edid_block_check_chk #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned EST_W  = 24,
  parameter int unsigned LAST   = 127
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             abort_i,
  input logic             byte_vld_i,
  input logic [IDX_W-1:0] byte_idx_i,
  input logic             active_q,
  input logic             done_o,
  input logic             hdr_ok_o,
  input logic             sum_ok_o,
  input logic             valid_o,
  input logic [EST_W-1:0] est_o
);
  AST_VALID_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (hdr_ok_o && sum_ok_o)); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !abort_i && (active_q || start_i) && byte_idx_i == IDX_W'(LAST))
    |=> done_o); // R6

  AST_RESULTS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i && !abort_i)
    |=> (done_o && $stable({hdr_ok_o, sum_ok_o, valid_o, est_o}))); // R7

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!done_o && !valid_o && !active_q)); // R8

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(byte_vld_i && byte_idx_i == IDX_W'(LAST))) |=> !done_o); // R9
endmodule

bind edid_block_check edid_block_check_chk #(
  .IDX_W(IDX_W), .EST_W(EST_W), .LAST(BLK_BYTES - 1)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
  .byte_vld_i(byte_vld_i), .byte_idx_i(byte_idx_i), .active_q(active_q),
  .done_o(done_o), .hdr_ok_o(hdr_ok_o), .sum_ok_o(sum_ok_o),
  .valid_o(valid_o), .est_o(est_o)
);

// File: tb/edid_block_check_tb.sv
module edid_block_check_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        start_i, abort_i, byte_vld_i;
  logic [6:0]  byte_idx_i;
  logic [7:0]  byte_i;
  logic        done_o, hdr_ok_o, sum_ok_o, valid_o;
  logic [23:0] est_o;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [7:0]  blk [128];

  always #10 clk = ~clk;

  edid_block_check u_dut (
    .clk_i(clk), .rst_ni, .start_i, .abort_i, .byte_vld_i, .byte_idx_i, .byte_i,
    .done_o, .hdr_ok_o, .sum_ok_o, .valid_o, .est_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hdr();
    for (int i = 0; i < 8; i++)
      if (blk[i] != ((i == 0 || i == 7) ? 8'h00 : 8'hFF)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit exp_sum();
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 128; i++) s += blk[i];
    return s == 8'h00;
  endfunction

  // kind bit0: corrupt header, bit1: corrupt checksum
  task automatic make_block(int kind);
    logic [7:0] s;
    for (int i = 0; i < 128; i++) blk[i] = 8'($urandom);
    for (int i = 0; i < 8; i++) blk[i] = (i == 0 || i == 7) ? 8'h00 : 8'hFF;
    if (kind[0]) begin
      int p = $urandom % 8;
      blk[p] = blk[p] ^ 8'(1 + $urandom % 255);
    end
    s = 8'h00;
    for (int i = 0; i < 127; i++) s += blk[i];
    blk[127] = 8'h00 - s;
    if (kind[1]) blk[127] = blk[127] + 8'(1 + $urandom % 255);
  endtask

  task automatic send_block(bit joined);
    if (!joined) begin
      @(negedge clk); start_i = 1'b1; byte_vld_i = 1'b0;
    end
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      start_i    = joined && (i == 0);
      byte_vld_i = 1'b1;
      byte_idx_i = 7'(i);
      byte_i     = blk[i];
    end
    @(negedge clk);
    start_i = 1'b0; byte_vld_i = 1'b0;
  endtask

  task automatic check_results(string tag);
    bit h = exp_hdr();
    bit s = exp_sum();
    check({tag, " R6 done"}, 32'(done_o), 32'd1);
    check({tag, " R1/R2 hdr_ok"}, 32'(hdr_ok_o), 32'(h));
    check({tag, " R3 sum_ok"}, 32'(sum_ok_o), 32'(s));
    check({tag, " R4 valid"}, 32'(valid_o), 32'(h && s));
    check({tag, " R5 est"}, 32'(est_o), {8'h00, blk[37], blk[36], blk[35]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; start_i = 1'b0; abort_i = 1'b0;
    byte_vld_i = 1'b0; byte_idx_i = '0; byte_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 reset done", 32'(done_o), 32'd0);
    check("R10 reset flags", {29'd0, hdr_ok_o, sum_ok_o, valid_o}, 32'd0);
    check("R10 reset est", 32'(est_o), 32'd0);

    // good block, separate start
    make_block(0);
    send_block(1'b0);
    check_results("good");

    // R7: late bytes after done are ignored
    snap = {5'd0, done_o, hdr_ok_o, valid_o, est_o};
    @(negedge clk); byte_vld_i = 1'b1; byte_idx_i = 7'd35; byte_i = ~blk[35];
    @(negedge clk); byte_idx_i = 7'd0; byte_i = 8'h5A;
    @(negedge clk); byte_idx_i = 7'd127; byte_i = blk[127] + 8'd1;
    @(negedge clk); byte_vld_i = 1'b0;
    check("R7 hold after late bytes", {5'd0, done_o, hdr_ok_o, valid_o, est_o}, snap);
    check("R7 sum_ok held", 32'(sum_ok_o), 32'd1);

    // R2: bad header, good sum
    make_block(1);
    send_block(1'b0);
    check_results("badhdr R2");

    // R3: good header, bad sum
    make_block(2);
    send_block(1'b1);
    check_results("badsum R3");

    // R9: start alone clears results
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R9 start clears done", 32'(done_o), 32'd0);
    check("R9 start clears est", 32'(est_o), 32'd0);

    // R8: abort together with the final byte
    make_block(0);
    @(negedge clk); start_i = 1'b1;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      start_i = 1'b0; byte_vld_i = 1'b1; byte_idx_i = 7'(i); byte_i = blk[i];
      abort_i = (i == 127);
    end
    @(negedge clk); abort_i = 1'b0; byte_vld_i = 1'b0;
    check("R8 abort with last byte done", 32'(done_o), 32'd0);
    check("R8 abort with last byte valid", 32'(valid_o), 32'd0);
    @(negedge clk); byte_vld_i = 1'b1; byte_idx_i = 7'd127; byte_i = blk[127];
    @(negedge clk); byte_vld_i = 1'b0;
    @(negedge clk);
    check("R8 byte after abort ignored", 32'(done_o), 32'd0);

    // R9: start together with byte 0 on a good block
    make_block(0);
    send_block(1'b1);
    check_results("joined R9");

    // random mix
    for (int t = 0; t < 24; t++) begin
      make_block(int'($urandom % 4));
      send_block(1'($urandom % 2));
      check_results("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule